// File: doc/BRIEF.md
# Modem Status Loopback Logic

This block holds the modem-status byte of a 16550-style serial port and fills it while the port runs in internal loopback. The modem-control byte is presented as an input. While its loop bit is set, each tick strobe copies the four control outputs onto the four status lines through a fixed cross-mapping. In the same tick, any line that changes raises a sticky change flag. The ring line is the exception: its flag is raised only when the line falls. When loopback is off, the status byte keeps its last value and no flag is raised.

Reading the status byte, signalled by a one-cycle read strobe, clears the whole byte on the following edge. A registered interrupt condition is raised while the interrupt enable is set and at least one change flag is set. The block also steers each transmitted character: in loopback it goes back to the receive side, and otherwise it goes to the serial output.

Top module: `mdm_loop_status`

## Requirements
- R1: After a synchronous reset, `msr_o`, `irq_o`, `ser_valid_o`, `rx_valid_o`, `ser_char_o` and `rx_char_o` are all zero.
- R2: On an edge where `tick_i` is high and `mcr_i[4]` (loop) is high, the status bits take these values: `msr_o[4]` (clear-to-send) from `mcr_i[1]` (request-to-send), `msr_o[5]` (data-set-ready) from `mcr_i[0]` (terminal-ready), `msr_o[6]` (ring) from `mcr_i[2]` (aux output 1) and `msr_o[7]` (carrier) from `mcr_i[3]` (aux output 2).
- R3: On such an update, `msr_o[0]`, `msr_o[1]` and `msr_o[3]` are set when the new value of bit 4, 5 or 7 respectively differs from its value before the update. Once set, they stay set until a read.
- R4: `msr_o[2]` is set only when bit 6 goes from 1 to 0 in an update. A rising ring line leaves it unchanged.
- R5: On an edge where `tick_i` is low or the loop bit is low, and `rd_i` is low, `msr_o` keeps its value.
- R6: When `rd_i` is high at an edge, all eight bits of `msr_o` are zero after that edge. If `tick_i` and loop are also high in that edge, the update of R2 to R4 is applied to the cleared byte.
- R7: `irq_o` is registered and equals `msi_en_i` at the previous edge ANDed with the OR of `msr_o[3:0]`.
- R8: A character offered with `tx_valid_i` appears one cycle later on `rx_char_o` with a one-cycle `rx_valid_o` pulse when loop is set, and otherwise on `ser_char_o` with `ser_valid_o`. The side that does not receive it keeps its last character.
- R9: `mcr_i[7:5]` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mcr_i | input | 8 | Modem-control byte: [0] terminal-ready, [1] request-to-send, [2] aux1, [3] aux2, [4] loop |
| tick_i | input | 1 | Update strobe for the looped status lines |
| rd_i | input | 1 | Status-byte read strobe, clears the byte |
| msi_en_i | input | 1 | Modem-status interrupt enable |
| tx_valid_i | input | 1 | Transmit character offered |
| tx_char_i | input | CHAR_W | Transmit character |
| msr_o | output | 8 | Modem-status byte |
| irq_o | output | 1 | Modem-status interrupt condition |
| ser_valid_o | output | 1 | Character sent to the serial output |
| ser_char_o | output | CHAR_W | Serial-output character |
| rx_valid_o | output | 1 | Character looped back to the receive side |
| rx_char_o | output | CHAR_W | Looped-back character |

## Verification
Directed sequences drive the ring line high and then low. This separates a rising edge, which must not raise its flag, from a falling edge, which must. Separate sequences apply a read in the same cycle as an update, which shows whether the update sees the cleared byte or the old one, and set only the unused control bits, which shows they are ignored. Seeded random control bytes, ticks, reads and characters, with loop on about three quarters of the time, then test the cross-mapping, flag stickiness, holding while loop is off, interrupt timing and character steering. Every cycle of that run is compared with a reference model written from the requirements.

// File: rtl/mdm_loop_pkg.sv
package mdm_loop_pkg;
  localparam int CTL_DTR  = 0;
  localparam int CTL_RTS  = 1;
  localparam int CTL_AUX1 = 2;
  localparam int CTL_AUX2 = 3;
  localparam int CTL_LOOP = 4;

  localparam int NUM_LINES = 4;
  localparam int RING_IDX  = 2;

  typedef struct packed {
    logic dcd;
    logic ri;
    logic dsr;
    logic cts;
  } line_t;
endpackage

// File: rtl/mdm_loop_map.sv
module mdm_loop_map
  import mdm_loop_pkg::*;
(
  input  logic [7:0] ctrl_i,
  output line_t      line_o,
  output logic       loop_o
);
  always_comb begin
    line_o.cts = ctrl_i[CTL_RTS];
    line_o.dsr = ctrl_i[CTL_DTR];
    line_o.ri  = ctrl_i[CTL_AUX1];
    line_o.dcd = ctrl_i[CTL_AUX2];
    loop_o     = ctrl_i[CTL_LOOP];
  end
endmodule

// File: rtl/mdm_status_reg.sv
module mdm_status_reg
  import mdm_loop_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic       loop_i,
  input  logic       rd_i,
  input  logic       msi_en_i,
  input  line_t      looped_i,
  output logic [7:0] msr_o,
  output logic       irq_o
);
  logic [NUM_LINES-1:0] lvl_q, dlt_q, irq_dummy;
  logic [NUM_LINES-1:0] new_lvl, base_lvl, base_dlt, hit, nxt_lvl, nxt_dlt;
  logic                 upd, irq_q;

  assign new_lvl  = looped_i;
  assign upd      = tick_i & loop_i;
  assign base_lvl = rd_i ? '0 : lvl_q;
  assign base_dlt = rd_i ? '0 : dlt_q;
  assign irq_dummy = '0;

  for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
    if (k == RING_IDX) begin : g_trail
      assign hit[k] = base_lvl[k] & ~new_lvl[k];
    end else begin : g_change
      assign hit[k] = base_lvl[k] ^ new_lvl[k];
    end
  end

  assign nxt_dlt = base_dlt | (upd ? hit : irq_dummy);
  assign nxt_lvl = upd ? new_lvl : base_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= '0;
      dlt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      lvl_q <= nxt_lvl;
      dlt_q <= nxt_dlt;
      irq_q <= msi_en_i & (|nxt_dlt);
    end
  end

  assign msr_o = {lvl_q, dlt_q};
  assign irq_o = irq_q;

  assert_map_R2: assert property (@(posedge clk) disable iff (rst)
    (tick_i && loop_i) |=> (msr_o[7:4] == $past(looped_i)));
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!rd_i && !(tick_i && loop_i)) |=> $stable(msr_o));
  assert_trail_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(msr_o[2]) |-> $fell(msr_o[6]));
  assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_i && !(tick_i && loop_i)) |=> (msr_o == 8'h00));
  assert_irq_R7: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (|msr_o[3:0]));
endmodule

// File: rtl/mdm_char_route.sv
module mdm_char_route #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loop_i,
  input  logic              tx_valid_i,
  input  logic [CHAR_W-1:0] tx_char_i,
  output logic              ser_valid_o,
  output logic [CHAR_W-1:0] ser_char_o,
  output logic              rx_valid_o,
  output logic [CHAR_W-1:0] rx_char_o
);
  logic              ser_v_q, rx_v_q;
  logic [CHAR_W-1:0] ser_c_q, rx_c_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ser_v_q <= 1'b0;
      rx_v_q  <= 1'b0;
      ser_c_q <= '0;
      rx_c_q  <= '0;
    end else begin
      ser_v_q <= tx_valid_i & ~loop_i;
      rx_v_q  <= tx_valid_i & loop_i;
      if (tx_valid_i && !loop_i) ser_c_q <= tx_char_i;
      if (tx_valid_i && loop_i)  rx_c_q  <= tx_char_i;
    end
  end

  assign ser_valid_o = ser_v_q;
  assign ser_char_o  = ser_c_q;
  assign rx_valid_o  = rx_v_q;
  assign rx_char_o   = rx_c_q;

  assert_one_side_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ser_valid_o, rx_valid_o}));
  assert_rx_char_R8: assert property (@(posedge clk) disable iff (rst)
    (tx_valid_i && loop_i) |=> (rx_valid_o && rx_char_o == $past(tx_char_i)));
  assert_ser_keep_R8: assert property (@(posedge clk) disable iff (rst)
    (tx_valid_i && loop_i) |=> $stable(ser_char_o));
endmodule

// File: rtl/mdm_loop_status.sv
module mdm_loop_status
  import mdm_loop_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        mcr_i,
  input  logic              tick_i,
  input  logic              rd_i,
  input  logic              msi_en_i,
  input  logic              tx_valid_i,
  input  logic [CHAR_W-1:0] tx_char_i,
  output logic [7:0]        msr_o,
  output logic              irq_o,
  output logic              ser_valid_o,
  output logic [CHAR_W-1:0] ser_char_o,
  output logic              rx_valid_o,
  output logic [CHAR_W-1:0] rx_char_o
);
  line_t looped;
  logic  loop_en;

  mdm_loop_map u_map (
    .ctrl_i (mcr_i),
    .line_o (looped),
    .loop_o (loop_en)
  );

  mdm_status_reg u_status (
    .clk      (clk),
    .rst      (rst),
    .tick_i   (tick_i),
    .loop_i   (loop_en),
    .rd_i     (rd_i),
    .msi_en_i (msi_en_i),
    .looped_i (looped),
    .msr_o    (msr_o),
    .irq_o    (irq_o)
  );

  mdm_char_route #(.CHAR_W(CHAR_W)) u_route (
    .clk         (clk),
    .rst         (rst),
    .loop_i      (loop_en),
    .tx_valid_i  (tx_valid_i),
    .tx_char_i   (tx_char_i),
    .ser_valid_o (ser_valid_o),
    .ser_char_o  (ser_char_o),
    .rx_valid_o  (rx_valid_o),
    .rx_char_o   (rx_char_o)
  );
endmodule

// File: tb/mdm_loop_status_bench.sv
module mdm_loop_status_bench;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic [7:0]    mcr;
  logic          tick, rd, en, txv;
  logic [CW-1:0] txc;
  logic [7:0]    msr;
  logic          irq, serv, rxv;
  logic [CW-1:0] serc, rxc;

  int total = 0;
  int bad   = 0;

  logic [7:0]    e_msr;
  logic          e_irq, e_serv, e_rxv;
  logic [CW-1:0] e_serc, e_rxc;

  always #4 clk = ~clk;

  mdm_loop_status #(.CHAR_W(CW)) u_mdm_loop_status (
    .clk(clk), .rst(rst), .mcr_i(mcr), .tick_i(tick), .rd_i(rd),
    .msi_en_i(en), .tx_valid_i(txv), .tx_char_i(txc),
    .msr_o(msr), .irq_o(irq), .ser_valid_o(serv), .ser_char_o(serc),
    .rx_valid_o(rxv), .rx_char_o(rxc)
  );

  function automatic logic [7:0] model_next(input logic [7:0] cur, input logic [7:0] c,
                                            input logic tk, input logic r);
    logic [7:0] m;
    logic cts, dsr, ri, dcd;
    m = r ? 8'h00 : cur;
    if (tk && c[4]) begin
      cts = c[1]; dsr = c[0]; ri = c[2]; dcd = c[3];
      if (cts != m[4]) m[0] = 1'b1;
      if (dsr != m[5]) m[1] = 1'b1;
      if (m[6] && !ri) m[2] = 1'b1;
      if (dcd != m[7]) m[3] = 1'b1;
      m[7:4] = {dcd, ri, dsr, cts};
    end
    return m;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    e_msr = model_next(e_msr, mcr, tick, rd);
    e_irq = en & (|e_msr[3:0]);
    e_serv = txv & ~mcr[4];
    e_rxv  = txv & mcr[4];
    if (txv && !mcr[4]) e_serc = txc;
    if (txv && mcr[4])  e_rxc  = txc;
    #1;
  endtask

  task automatic check_all();
    check("R2 status lines", {24'h0, msr[7:4]}, {24'h0, e_msr[7:4]});
    check("R3 change flags", {29'h0, msr[3], msr[1:0]}, {29'h0, e_msr[3], e_msr[1:0]});
    check("R4 ring trailing flag", {31'h0, msr[2]}, {31'h0, e_msr[2]});
    check("R7 interrupt", {31'h0, irq}, {31'h0, e_irq});
    check("R8 routing valids", {30'h0, serv, rxv}, {30'h0, e_serv, e_rxv});
    check("R8 routing chars", {16'h0, serc, rxc}, {16'h0, e_serc, e_rxc});
  endtask

  task automatic drive(input logic [7:0] c, input logic tk, input logic r,
                       input logic e, input logic v, input logic [CW-1:0] ch);
    mcr = c; tick = tk; rd = r; en = e; txv = v; txc = ch;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    logic [31:0] rv;
    seed = 32'd1234;
    rv = $urandom(seed);
    rst = 1'b1;
    drive(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    e_msr = 8'h00; e_irq = 1'b0; e_serv = 1'b0; e_rxv = 1'b0; e_serc = '0; e_rxc = '0;
    @(posedge clk); @(posedge clk); #1;
    check("R1 reset msr", {24'h0, msr}, 32'h0);
    check("R1 reset outputs", {14'h0, irq, serv, rxv, rxc, serc}, 32'h0);
    rst = 1'b0;

    // R9: only unused control bits, with loop off
    drive(8'hE0, 1'b1, 1'b0, 1'b1, 1'b0, '0); step();
    check("R9 unused bits, loop off", {24'h0, msr}, 32'h0);
    // R9: unused bits with loop on and all control outputs low
    drive(8'hF0, 1'b1, 1'b0, 1'b1, 1'b0, '0); step();
    check("R9 unused bits, loop on", {24'h0, msr}, 32'h0);
    check("R9 no interrupt", {31'h0, irq}, 32'h0);

    // R4: ring rises, no trailing flag
    drive(8'h14, 1'b1, 1'b0, 1'b1, 1'b0, '0); step();
    check("R4 ring rise", {24'h0, msr}, 32'h40);
    check("R7 no flag no irq", {31'h0, irq}, 32'h0);
    // R4: ring falls, trailing flag
    drive(8'h10, 1'b1, 1'b0, 1'b1, 1'b0, '0); step();
    check("R4 ring fall", {24'h0, msr}, 32'h04);
    check("R7 irq on flag", {31'h0, irq}, 32'h1);
    // R6: read clears
    drive(8'h10, 1'b0, 1'b1, 1'b1, 1'b0, '0); step();
    check("R6 read clears", {24'h0, msr}, 32'h00);
    // R2/R3: all four lines high
    drive(8'h1F, 1'b1, 1'b0, 1'b0, 1'b0, '0); step();
    check("R2 R3 all lines up", {24'h0, msr}, 32'hFB);
    check("R7 enable low", {31'h0, irq}, 32'h0);
    // R5: loop off, tick, outputs change -> hold
    drive(8'h00, 1'b1, 1'b0, 1'b0, 1'b0, '0); step();
    check("R5 hold loop off", {24'h0, msr}, 32'hFB);
    // R6: read with update, update sees cleared byte
    drive(8'h13, 1'b1, 1'b1, 1'b0, 1'b0, '0); step();
    check("R6 read with tick", {24'h0, msr}, 32'h33);
    // R5: loop on but no tick
    drive(8'h10, 1'b0, 1'b0, 1'b0, 1'b0, '0); step();
    check("R5 hold no tick", {24'h0, msr}, 32'h33);
    // R8 directed
    drive(8'h10, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA5); step();
    check("R8 loop char", {23'h0, rxv, rxc}, {23'h0, 1'b1, 8'hA5});
    drive(8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'h3C); step();
    check("R8 serial char", {15'h0, serv, serc, rxv, rxc}, {15'h0, 1'b1, 8'h3C, 1'b0, 8'hA5});
    e_msr = msr;
    check_all();

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom();
      drive({r[7:5], (r[9:8] != 2'b00), r[3:0]}, r[10], (r[13:11] == 3'd0),
            r[14], r[15], r[23:16]);
      step();
      check_all();
    end

    drive(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule